// File: doc/BRIEF.md
# Byte-Lane Static Memory Core

A behavioural, synthesizable model of a 16-bit-wide static memory. Its control interface follows the classic asynchronous style and uses active-low signals. A pair of chip enables with opposite polarity selects the part. A write enable and an output enable choose the direction of an access. Two byte enables gate the low lane (data bits 7:0) and the high lane (data bits 15:8) independently of each other. The bidirectional data bus is split into a data-in vector, a data-out vector and one output-enable bit per lane. Surrounding logic builds the tri-state pads from these.

Writes update the array on the rising clock edge while the write condition holds, so the model can be synthesized. Reads are combinational from the current address and the stored contents. A byte-organised mode turns the part into a twice-as-deep, 8-bit-wide memory. In that mode an extra low-order address bit picks the half of the word, and only the low lane carries data. A standby flag reports when the part is deselected or when both lanes are disabled. Only the low address bits are implemented, so simulation can use a small depth. The upper address bits alias onto those words.

Top module: `sram_lane_core`

## Requirements
- R1: The part is selected only when `ce_a_n` is 0 and `ce_b` is 1. Any other combination deselects it. While deselected, no lane drives and no write takes place.
- R2: `standby` is 1 exactly when the part is deselected or when both `hi_en_n` and `lo_en_n` are 1.
- R3: In word mode (`byte_mode`=0), a selected cycle with `wr_n`=0 stores data at the next rising clock edge, in word `addr` modulo the implemented depth. Bits 7:0 of `din` are stored when `lo_en_n`=0, and bits 15:8 when `hi_en_n`=0. A lane whose enable is 1 keeps its old contents.
- R4: In word mode, a selected cycle with `rd_oe_n`=0 and `wr_n`=1 is a read. `lane_oe[0]` is set and `dout[7:0]` shows stored bits 7:0 when `lo_en_n`=0. `lane_oe[1]` is set and `dout[15:8]` shows stored bits 15:8 when `hi_en_n`=0.
- R5: `lane_oe` is 00 whenever any of these holds: the part is deselected, `rd_oe_n`=1, both byte enables are 1, or `wr_n`=0. `wr_n`=0 forces 00 whatever the value of `rd_oe_n`.
- R6: When a lane's `lane_oe` bit is 0, that lane's 8 bits of `dout` are 0.
- R7: In byte mode (`byte_mode`=1), `byte_sel`=0 addresses stored bits 7:0 of the word and `byte_sel`=1 addresses bits 15:8. Reads return the selected byte on `dout[7:0]`, gated by `lo_en_n`. Writes store `din[7:0]` into the selected byte, gated by `lo_en_n`. `lane_oe[1]` stays 0, and `hi_en_n` affects only `standby`.
- R8: A cycle with `wr_n`=0 while deselected, or with both byte enables at 1, leaves every stored word unchanged.
- R9: Reset (`rst_n`=0) clears every stored word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; array writes take effect on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset clearing the array |
| addr | input | ADDR_W (20) | Word address; low WORD_AW bits are implemented |
| byte_sel | input | 1 | Half-word select in byte mode (0 = bits 7:0) |
| byte_mode | input | 1 | 1 = 8-bit organisation, 0 = 16-bit |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| wr_n | input | 1 | Write enable, active low |
| rd_oe_n | input | 1 | Output enable, active low |
| hi_en_n | input | 1 | High-lane enable, active low |
| lo_en_n | input | 1 | Low-lane enable, active low |
| din | input | 16 | Data from the bus pads |
| dout | output | 16 | Data to the bus pads, zero on idle lanes |
| lane_oe | output | 2 | Pad drive enable per lane (bit 0 low lane) |
| standby | output | 1 | Power-down condition indicator |

## Verification
The bench first sweeps all 128 combinations of the six control inputs and the mode bit. This separates the four high-impedance causes and the standby conditions from each other, and it shows that a write suppresses output drive. Random word-mode traffic over a handful of aliasing addresses uses mixed lane enables. It tells a one-lane write apart from a full-word write, and shows whether a stale or a just-written value reaches the bus. Random byte-mode traffic checks that the half-select bit steers both reads and writes to the intended byte, while the high lane stays silent. A burst of writes while deselected or with both lanes disabled is followed by a full read-back, which exposes any stray store.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    // Decoded access strobes: rd_* are bus lanes, wr_* are word halves
    typedef struct packed {
        logic sel;
        logic standby;
        logic rd_lo;
        logic rd_hi;
        logic wr_lo;
        logic wr_hi;
    } access_t;

endpackage

// File: rtl/sram_ctrl_decode.sv
module sram_ctrl_decode
    import sram_lane_pkg::*;
(
    input  logic    byte_mode,
    input  logic    byte_sel,
    input  logic    ce_a_n,
    input  logic    ce_b,
    input  logic    wr_n,
    input  logic    rd_oe_n,
    input  logic    hi_en_n,
    input  logic    lo_en_n,
    output access_t acc
);

    logic writing;
    logic reading;

    always_comb begin
        acc         = '0;
        acc.sel     = ~ce_a_n & ce_b;
        acc.standby = ~acc.sel | (hi_en_n & lo_en_n);
        writing     = acc.sel & ~wr_n;
        reading     = acc.sel & wr_n & ~rd_oe_n;
        if (byte_mode) begin
            acc.rd_lo = reading & ~lo_en_n;
            acc.rd_hi = 1'b0;
            acc.wr_lo = writing & ~lo_en_n & ~byte_sel;
            acc.wr_hi = writing & ~lo_en_n & byte_sel;
        end else begin
            acc.rd_lo = reading & ~lo_en_n;
            acc.rd_hi = reading & ~hi_en_n;
            acc.wr_lo = writing & ~lo_en_n;
            acc.wr_hi = writing & ~hi_en_n;
        end
    end

endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array
    import sram_lane_pkg::*;
#(
    parameter int WORD_AW = 6,
    localparam int DEPTH  = 1 << WORD_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_AW-1:0] idx,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [BYTE_W-1:0]  wdata_lo,
    input  logic [BYTE_W-1:0]  wdata_hi,
    output logic [DATA_W-1:0]  rd_word
);

    logic [DEPTH-1:0][DATA_W-1:0] mem_d;
    logic [DEPTH-1:0][DATA_W-1:0] mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_lo) mem_d[idx][BYTE_W-1:0]      = wdata_lo;
        if (wr_hi) mem_d[idx][DATA_W-1:BYTE_W] = wdata_hi;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rd_word = mem_q[idx];

    // Without a strobe, the whole array is frozen
    assert_no_stray_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lo || wr_hi) |=> mem_q == $past(mem_q));

    // An unstrobed half of the addressed word is kept
    assert_hi_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> mem_q[$past(idx)][DATA_W-1:BYTE_W] == $past(mem_q[idx][DATA_W-1:BYTE_W]));

    assert_lo_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> mem_q[$past(idx)][BYTE_W-1:0] == $past(mem_q[idx][BYTE_W-1:0]));

endmodule

// File: rtl/sram_read_mux.sv
module sram_read_mux
    import sram_lane_pkg::*;
(
    input  logic              byte_mode,
    input  logic              byte_sel,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] dout,
    output logic [1:0]        lane_oe
);

    logic [BYTE_W-1:0] lo_src;

    always_comb begin
        if (byte_mode && byte_sel) lo_src = word[DATA_W-1:BYTE_W];
        else                       lo_src = word[BYTE_W-1:0];
        dout    = '0;
        lane_oe = {rd_hi, rd_lo};
        if (rd_lo) dout[BYTE_W-1:0]      = lo_src;
        if (rd_hi) dout[DATA_W-1:BYTE_W] = word[DATA_W-1:BYTE_W];
    end

endmodule

// File: rtl/sram_lane_core.sv
module sram_lane_core
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int WORD_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              byte_sel,
    input  logic              byte_mode,
    input  logic              ce_a_n,
    input  logic              ce_b,
    input  logic              wr_n,
    input  logic              rd_oe_n,
    input  logic              hi_en_n,
    input  logic              lo_en_n,
    input  logic [15:0]       din,
    output logic [15:0]       dout,
    output logic [1:0]        lane_oe,
    output logic              standby
);

    access_t           acc;
    logic [DATA_W-1:0] rd_word;
    logic [BYTE_W-1:0] wdata_hi;
    logic [WORD_AW-1:0] idx;

    assign idx = addr[WORD_AW-1:0];

    generate
        if (WORD_AW < ADDR_W) begin : g_alias
            logic unused_addr_hi;
            assign unused_addr_hi = ^addr[ADDR_W-1:WORD_AW];
        end
    endgenerate

    sram_ctrl_decode u_dec (
        .byte_mode (byte_mode),
        .byte_sel  (byte_sel),
        .ce_a_n    (ce_a_n),
        .ce_b      (ce_b),
        .wr_n      (wr_n),
        .rd_oe_n   (rd_oe_n),
        .hi_en_n   (hi_en_n),
        .lo_en_n   (lo_en_n),
        .acc       (acc)
    );

    // Byte mode routes the low bus lane into either word half
    assign wdata_hi = byte_mode ? din[BYTE_W-1:0] : din[DATA_W-1:BYTE_W];

    sram_byte_array #(.WORD_AW(WORD_AW)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (idx),
        .wr_lo    (acc.wr_lo),
        .wr_hi    (acc.wr_hi),
        .wdata_lo (din[BYTE_W-1:0]),
        .wdata_hi (wdata_hi),
        .rd_word  (rd_word)
    );

    sram_read_mux u_mux (
        .byte_mode (byte_mode),
        .byte_sel  (byte_sel),
        .rd_lo     (acc.rd_lo),
        .rd_hi     (acc.rd_hi),
        .word      (rd_word),
        .dout      (dout),
        .lane_oe   (lane_oe)
    );

    assign standby = acc.standby;

    assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ce_a_n && ce_b) |-> (lane_oe == 2'b00) && standby);

    assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> lane_oe == 2'b00);

    assert_write_hides_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> lane_oe == 2'b00);

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_oe[0] |-> dout[7:0] == 8'h00);

    assert_idle_zero_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_oe[1] |-> dout[15:8] == 8'h00);

    assert_byte_hi_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_mode |-> !lane_oe[1] && $onehot0({acc.wr_lo, acc.wr_hi}));

endmodule

// File: tb/tb_sram_lane_core.sv
module tb_sram_lane_core;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 6;
    localparam int DEPTH      = 1 << AW;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [19:0] addr;
    logic        byte_sel, byte_mode, ce_a_n, ce_b, wr_n, rd_oe_n, hi_en_n, lo_en_n;
    logic [15:0] din;
    logic [15:0] dout;
    logic [1:0]  lane_oe;
    logic        standby;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [15:0] ref_mem [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_lane_core #(.ADDR_W(20), .WORD_AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .byte_sel(byte_sel),
        .byte_mode(byte_mode), .ce_a_n(ce_a_n), .ce_b(ce_b), .wr_n(wr_n),
        .rd_oe_n(rd_oe_n), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n), .din(din),
        .dout(dout), .lane_oe(lane_oe), .standby(standby)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare model vs outputs, then apply write to model
    task automatic step(input string tag, input logic [19:0] a, input logic bm, input logic bs,
                        input logic c1n, input logic c2, input logic wn, input logic oen,
                        input logic hn, input logic ln, input logic [15:0] d);
        bit sel, stby, rd, wr;
        int w;
        logic [15:0] word, e_out;
        logic [1:0]  e_oe;
        @(negedge clk);
        addr = a; byte_mode = bm; byte_sel = bs; ce_a_n = c1n; ce_b = c2;
        wr_n = wn; rd_oe_n = oen; hi_en_n = hn; lo_en_n = ln; din = d;
        #1;
        w    = int'(a) % DEPTH;
        word = ref_mem[w];
        sel  = (c1n == 1'b0) && (c2 == 1'b1);
        stby = !sel || (hn && ln);
        rd   = sel && wn && !oen;
        wr   = sel && !wn;
        e_oe = 2'b00; e_out = 16'h0000;
        if (rd && !ln) begin
            e_oe[0] = 1'b1;
            e_out[7:0] = (bm && bs) ? word[15:8] : word[7:0];
        end
        if (rd && !hn && !bm) begin
            e_oe[1] = 1'b1;
            e_out[15:8] = word[15:8];
        end
        check(tag, "lane_oe", {14'd0, lane_oe}, {14'd0, e_oe});
        check(tag, "dout", dout, e_out);
        check("R2", "standby", {15'd0, standby}, {15'd0, stby});
        if (wr) begin
            if (bm) begin
                if (!ln) begin
                    if (bs) ref_mem[w][15:8] = d[7:0];
                    else    ref_mem[w][7:0]  = d[7:0];
                end
            end else begin
                if (!ln) ref_mem[w][7:0]  = d[7:0];
                if (!hn) ref_mem[w][15:8] = d[15:8];
            end
        end
    endtask

    task automatic read_back(input string tag);
        for (int i = 0; i < DEPTH; i++)
            step(tag, 20'(i), 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    endtask

    initial begin
        rst_n = 1'b0; addr = '0; byte_sel = 0; byte_mode = 0; ce_a_n = 1; ce_b = 0;
        wr_n = 1; rd_oe_n = 1; hi_en_n = 1; lo_en_n = 1; din = '0;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        // R9: outputs in reset are idle, array reads back as zero afterwards
        #1;
        check("R9", "reset lane_oe", {14'd0, lane_oe}, 16'h0);
        check("R9", "reset standby", {15'd0, standby}, 16'h1);
        rst_n = 1'b1;
        read_back("R9");

        // R1 R2 R5 R6: every control combination in both organisations
        for (int c = 0; c < 128; c++) begin
            logic [6:0] v;
            v = 7'(c);
            step("R1/R5", {$urandom} % 20'hFFFFF, v[6], $urandom % 2, v[5], v[4], v[3], v[2], v[1], v[0], 16'($urandom));
        end

        // R3 R4 R6: word-mode traffic on a few aliasing addresses
        for (int n = 0; n < 1500; n++) begin
            logic [19:0] a;
            a = {12'($urandom), 2'b00, 6'($urandom % 4)};
            step("R3/R4", a, 1'b0, 1'b0, 1'b0, 1'b1, ($urandom % 3) == 0 ? 1'b0 : 1'b1,
                 $urandom % 2, $urandom % 2, $urandom % 2, 16'($urandom));
        end

        // R7: byte-mode traffic
        for (int n = 0; n < 1500; n++) begin
            step("R7", 20'($urandom % 4), 1'b1, $urandom % 2, 1'b0, 1'b1,
                 ($urandom % 3) == 0 ? 1'b0 : 1'b1, $urandom % 2, $urandom % 2,
                 $urandom % 2, 16'($urandom));
        end
        read_back("R3/R7");

        // R8: writes while deselected or with both lanes off
        for (int n = 0; n < 300; n++) begin
            int k;
            k = $urandom % 3;
            step("R8", 20'($urandom), $urandom % 2, $urandom % 2,
                 k == 0 ? 1'b1 : 1'b0, k == 1 ? 1'b0 : 1'b1, 1'b0, $urandom % 2,
                 k == 2 ? 1'b1 : 1'($urandom % 2), k == 2 ? 1'b1 : 1'($urandom % 2),
                 16'($urandom));
        end
        read_back("R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule